// File: doc/BRIEF.md
# Shadow Stack Return Checker

This block guards subroutine returns with a second copy of every return address, held in storage that no ordinary store can reach. A call event carries the current program counter, the instruction length and the call target. The block forms the return address, hands it out as a write to the ordinary data stack, and records the same value in its own shadow memory. It then moves both stack pointers down by one 8-byte slot and redirects the program counter to the target.

A return event carries the candidate address that was read from the data stack. The block compares that candidate with the top shadow entry. If they agree, the return proceeds. If they do not, a control-protection fault is raised and no architectural state moves. A separate check looks at the page attributes of each ordinary store and refuses any store aimed at a page marked as shadow stack. The shadow pointer can be read and loaded directly, so that an operating system can save and restore it on a context switch.

Top module: `shstk_guard`

## Requirements
- R1: After reset, `pc_o` is `PC_RST`, `dsp_o` is `DS_TOP`, `ssp_o` is `SS_TOP`, `flt_o` is 0 and `pc_vld_o` is 0.
- R2: A call strobe is accepted on a clock edge. In the next cycle `pc_vld_o`=1, `pc_o`=`call_tgt`, `dsp_o` has dropped by 8, and `dstk_wr_o`=1 with `dstk_addr_o`=new `dsp_o` and `dstk_data_o`=`call_pc`+`call_len`.
- R3: With `en`=1, a call also lowers `ssp_o` by 8 and stores the return address in the shadow slot at the new `ssp_o`.
- R4: With `en`=1, a return whose `ret_cand` equals the top shadow entry sets `pc_o`=`ret_cand` and raises both `dsp_o` and `ssp_o` by 8, with `pc_vld_o`=1 one cycle after the strobe.
- R5: With `en`=1, a return whose candidate differs from the top shadow entry sets `flt_o`=4'b0001 (control protection). `pc_o`, `dsp_o` and `ssp_o` keep their values and `pc_vld_o` stays 0.
- R6: A store strobe with present=1, writable=0 and dirty=1 sets `flt_o`=4'b0010 (general protection). Every other attribute combination leaves `flt_o` at 0. An event in the same cycle as a refused store is dropped.
- R7: The shadow memory holds `DEPTH` (16) entries. With `en`=1, a call made when `ssp_o` equals `SS_TOP`-8*`DEPTH` sets `flt_o`=4'b0100 (overflow) and changes no pointer.
- R8: With `en`=1, a return made when `ssp_o` equals `SS_TOP` sets `flt_o`=4'b1000 (underflow) and changes no pointer.
- R9: With `en`=0, a return takes `ret_cand` with no compare and no underflow check, and neither a call nor a return changes `ssp_o`.
- R10: Fault flags are one-hot and sticky. While any flag is set, call, return and store strobes have no effect. A `flt_clr` pulse clears the flags, and events in that cycle are ignored.
- R11: `ssp_o` always shows the shadow pointer, and `ssp_wr` loads `ssp_wdata` at the next edge. Events in that cycle are dropped. Shadow entries can be written only by the call path, so a saved pointer that is later restored finds its entries intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Shadow checking enable |
| call_vld | input | 1 | Call event strobe |
| call_pc | input | 64 | Program counter of the call |
| call_len | input | 4 | Length of the call instruction in bytes |
| call_tgt | input | 64 | Call target address |
| ret_vld | input | 1 | Return event strobe |
| ret_cand | input | 64 | Return address read from the data stack |
| st_vld | input | 1 | Ordinary store request strobe |
| pg_present | input | 1 | Store page: present attribute |
| pg_writable | input | 1 | Store page: writable attribute |
| pg_dirty | input | 1 | Store page: dirty attribute |
| flt_clr | input | 1 | Clear all fault flags |
| ssp_wr | input | 1 | Load the shadow pointer |
| ssp_wdata | input | 64 | Shadow pointer value to load |
| pc_o | output | 64 | Next program counter |
| pc_vld_o | output | 1 | `pc_o` updated by the event one cycle earlier |
| dsp_o | output | 64 | Data stack pointer |
| ssp_o | output | 64 | Shadow stack pointer |
| flt_o | output | 4 | Faults: bit0 control protection, bit1 general protection, bit2 overflow, bit3 underflow |
| dstk_wr_o | output | 1 | Return-address write to the data stack |
| dstk_addr_o | output | 64 | Address of that write |
| dstk_data_o | output | 64 | Return address written |

## Verification
The return check is driven in three ways: with candidates that match the shadow copy, with a forged candidate after a legitimate call, and with candidates when checking is disabled. Together these show that the compare is real, that its failure freezes the pointers, and that it is bypassed only by the enable. Sixteen nested calls followed by sixteen returns in reverse order confirm last-in, first-out ordering across every memory slot, and the extra call and extra return reach both boundary faults. The shadow pointer is saved, overwritten and restored, showing that entries survive the swap and that no other path altered them. Store requests sweep the page-attribute combinations, so that only the shadow marker is refused.

// File: rtl/shstk_pkg.sv
package shstk_pkg;
    localparam int FLT_N   = 4;
    localparam int FLT_CP  = 0;
    localparam int FLT_GP  = 1;
    localparam int FLT_OVF = 2;
    localparam int FLT_UNF = 3;
    typedef logic [FLT_N-1:0] flt_t;
endpackage

// File: rtl/shstk_mem.sv
// Shadow entry storage; single write port fed only by the call path.
module shstk_mem #(
    parameter int unsigned W     = 64,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [IDXW-1:0] widx,
    input  logic [W-1:0]    wdata,
    input  logic [IDXW-1:0] ridx,
    output logic [W-1:0]    rdata
);
    logic [W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slot_q[widx] <= wdata;
    end

    assign rdata = slot_q[ridx];
endmodule

// File: rtl/shstk_bounds.sv
// Occupancy limits of the shadow region.
module shstk_bounds #(
    parameter int unsigned  AW     = 64,
    parameter int unsigned  DEPTH  = 16,
    parameter logic [AW-1:0] SS_TOP = 64'h8000
) (
    input  logic [AW-1:0] ssp,
    output logic          full,
    output logic          empty
);
    localparam logic [AW-1:0] SPAN  = AW'(DEPTH) << 3;
    localparam logic [AW-1:0] FLOOR = SS_TOP - SPAN;

    assign empty = (ssp >= SS_TOP);
    assign full  = (ssp <= FLOOR);
endmodule

// File: rtl/shstk_page_chk.sv
// Refuses ordinary stores to pages carrying the shadow marker.
module shstk_page_chk (
    input  logic st_vld,
    input  logic present,
    input  logic writable,
    input  logic dirty,
    output logic illegal
);
    logic shadow_pg;
    assign shadow_pg = present & ~writable & dirty;
    assign illegal   = st_vld & shadow_pg;
endmodule

// File: rtl/shstk_guard.sv
module shstk_guard #(
    parameter int unsigned   AW     = 64,
    parameter int unsigned   LW     = 4,
    parameter int unsigned   DEPTH  = 16,
    parameter logic [AW-1:0] SS_TOP = 64'h0000_0000_0000_8000,
    parameter logic [AW-1:0] DS_TOP = 64'h0000_0000_0001_0000,
    parameter logic [AW-1:0] PC_RST = 64'h0000_0000_0000_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    call_vld,
    input  logic [AW-1:0]           call_pc,
    input  logic [LW-1:0]           call_len,
    input  logic [AW-1:0]           call_tgt,
    input  logic                    ret_vld,
    input  logic [AW-1:0]           ret_cand,
    input  logic                    st_vld,
    input  logic                    pg_present,
    input  logic                    pg_writable,
    input  logic                    pg_dirty,
    input  logic                    flt_clr,
    input  logic                    ssp_wr,
    input  logic [AW-1:0]           ssp_wdata,
    output logic [AW-1:0]           pc_o,
    output logic                    pc_vld_o,
    output logic [AW-1:0]           dsp_o,
    output logic [AW-1:0]           ssp_o,
    output logic [shstk_pkg::FLT_N-1:0] flt_o,
    output logic                    dstk_wr_o,
    output logic [AW-1:0]           dstk_addr_o,
    output logic [AW-1:0]           dstk_data_o
);
    import shstk_pkg::*;

    localparam int unsigned   IDXW = $clog2(DEPTH);
    localparam logic [AW-1:0] SLOT = AW'(8);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          pc_vld;
        logic [AW-1:0] dsp;
        logic [AW-1:0] ssp;
        flt_t          flt;
        logic          dw_vld;
        logic [AW-1:0] dw_addr;
        logic [AW-1:0] dw_data;
    } state_t;

    state_t s_d, s_q;

    logic            gp_hit;
    logic            ss_full, ss_empty;
    logic [AW-1:0]   ret_addr;
    logic [AW-1:0]   ssp_dec, ssp_inc, dsp_dec, dsp_inc;
    logic [AW-1:0]   shadow_top;
    logic            mem_we;
    logic [IDXW-1:0] mem_widx, mem_ridx;
    logic            evt_ok;

    shstk_page_chk u_pg (
        .st_vld   (st_vld),
        .present  (pg_present),
        .writable (pg_writable),
        .dirty    (pg_dirty),
        .illegal  (gp_hit)
    );

    shstk_bounds #(.AW(AW), .DEPTH(DEPTH), .SS_TOP(SS_TOP)) u_bnd (
        .ssp   (s_q.ssp),
        .full  (ss_full),
        .empty (ss_empty)
    );

    shstk_mem #(.W(AW), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .widx  (mem_widx),
        .wdata (ret_addr),
        .ridx  (mem_ridx),
        .rdata (shadow_top)
    );

    assign ret_addr = call_pc + AW'(call_len);
    assign ssp_dec  = s_q.ssp - SLOT;
    assign ssp_inc  = s_q.ssp + SLOT;
    assign dsp_dec  = s_q.dsp - SLOT;
    assign dsp_inc  = s_q.dsp + SLOT;
    assign mem_widx = ssp_dec[IDXW+2:3];
    assign mem_ridx = s_q.ssp[IDXW+2:3];
    assign evt_ok   = !flt_clr && !ssp_wr && (s_q.flt == '0);

    always_comb begin
        s_d        = s_q;
        s_d.pc_vld = 1'b0;
        s_d.dw_vld = 1'b0;
        mem_we     = 1'b0;

        if (flt_clr) s_d.flt = '0;
        if (ssp_wr)  s_d.ssp = ssp_wdata;

        if (evt_ok) begin
            if (gp_hit) begin
                s_d.flt[FLT_GP] = 1'b1;
            end else if (call_vld) begin
                if (en && ss_full) begin
                    s_d.flt[FLT_OVF] = 1'b1;
                end else begin
                    s_d.pc      = call_tgt;
                    s_d.pc_vld  = 1'b1;
                    s_d.dsp     = dsp_dec;
                    s_d.dw_vld  = 1'b1;
                    s_d.dw_addr = dsp_dec;
                    s_d.dw_data = ret_addr;
                    if (en) begin
                        s_d.ssp = ssp_dec;
                        mem_we  = 1'b1;
                    end
                end
            end else if (ret_vld) begin
                if (en && ss_empty) begin
                    s_d.flt[FLT_UNF] = 1'b1;
                end else if (en && (shadow_top != ret_cand)) begin
                    s_d.flt[FLT_CP] = 1'b1;
                end else begin
                    s_d.pc     = ret_cand;
                    s_d.pc_vld = 1'b1;
                    s_d.dsp    = dsp_inc;
                    if (en) s_d.ssp = ssp_inc;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.pc      <= PC_RST;
            s_q.pc_vld  <= 1'b0;
            s_q.dsp     <= DS_TOP;
            s_q.ssp     <= SS_TOP;
            s_q.flt     <= '0;
            s_q.dw_vld  <= 1'b0;
            s_q.dw_addr <= '0;
            s_q.dw_data <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pc_o        = s_q.pc;
    assign pc_vld_o    = s_q.pc_vld;
    assign dsp_o       = s_q.dsp;
    assign ssp_o       = s_q.ssp;
    assign flt_o       = s_q.flt;
    assign dstk_wr_o   = s_q.dw_vld;
    assign dstk_addr_o = s_q.dw_addr;
    assign dstk_data_o = s_q.dw_data;
endmodule

// File: rtl/shstk_guard_chk.sv
module shstk_guard_chk #(
    parameter int unsigned AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          st_vld,
    input logic          pg_present,
    input logic          pg_writable,
    input logic          pg_dirty,
    input logic          flt_clr,
    input logic          ssp_wr,
    input logic [AW-1:0] pc_o,
    input logic          pc_vld_o,
    input logic [AW-1:0] dsp_o,
    input logic [AW-1:0] ssp_o,
    input logic [3:0]    flt_o,
    input logic          dstk_wr_o
);
    // R10
    flt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flt_o));

    // R10
    flt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_o != 4'b0) && !flt_clr |=> flt_o == $past(flt_o));

    // R10
    flt_blocks_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_o != 4'b0) |=> !pc_vld_o && !dstk_wr_o);

    // R5
    cp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_o[0]) |-> $stable(pc_o) && $stable(dsp_o) && $stable(ssp_o) && !pc_vld_o);

    // R2
    call_dsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dstk_wr_o |-> dsp_o == $past(dsp_o) - 64'd8);

    // R6
    gp_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_vld && pg_present && !pg_writable && pg_dirty && (flt_o == 4'b0) && !flt_clr && !ssp_wr
        |=> flt_o == 4'b0010);

    // R9
    dis_ssp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !ssp_wr |=> $stable(ssp_o));
endmodule

bind shstk_guard shstk_guard_chk #(.AW(AW)) u_chk (.*);

// File: tb/shstk_guard_tb.sv
module shstk_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        call_vld = 1'b0;
    logic [63:0] call_pc = '0;
    logic [3:0]  call_len = '0;
    logic [63:0] call_tgt = '0;
    logic        ret_vld = 1'b0;
    logic [63:0] ret_cand = '0;
    logic        st_vld = 1'b0;
    logic        pg_present = 1'b0;
    logic        pg_writable = 1'b0;
    logic        pg_dirty = 1'b0;
    logic        flt_clr = 1'b0;
    logic        ssp_wr = 1'b0;
    logic [63:0] ssp_wdata = '0;
    logic [63:0] pc_o, dsp_o, ssp_o, dstk_addr_o, dstk_data_o;
    logic        pc_vld_o, dstk_wr_o;
    logic [3:0]  flt_o;

    int checks = 0;
    int errors = 0;
    logic [63:0] edsp;

    localparam logic [63:0] SST = 64'h8000;
    localparam logic [63:0] DST = 64'h1_0000;

    always #10 clk = ~clk;

    shstk_guard u_dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // strobe at a falling edge, sample at the next falling edge
    task automatic idle();
        call_vld = 0; ret_vld = 0; st_vld = 0; flt_clr = 0; ssp_wr = 0;
    endtask

    task automatic do_call(input logic [63:0] pc, input logic [3:0] len, input logic [63:0] tgt);
        @(negedge clk);
        call_vld = 1; call_pc = pc; call_len = len; call_tgt = tgt;
        @(negedge clk);
        idle();
    endtask

    task automatic do_ret(input logic [63:0] cand);
        @(negedge clk);
        ret_vld = 1; ret_cand = cand;
        @(negedge clk);
        idle();
    endtask

    task automatic do_clr();
        @(negedge clk);
        flt_clr = 1;
        @(negedge clk);
        idle();
    endtask

    task automatic test_reset();
        chk("R1 pc", pc_o, 64'h0);
        chk("R1 dsp", dsp_o, DST);
        chk("R1 ssp", ssp_o, SST);
        chk("R1 flt", {60'b0, flt_o}, 64'h0);
        chk("R1 vld", {63'b0, pc_vld_o}, 64'h0);
    endtask

    task automatic test_call_ret();
        do_call(64'h1000, 4'd5, 64'h2000);
        chk("R2 pc", pc_o, 64'h2000);
        chk("R2 vld", {63'b0, pc_vld_o}, 64'h1);
        chk("R2 dsp", dsp_o, DST - 8);
        chk("R2 wr", {63'b0, dstk_wr_o}, 64'h1);
        chk("R2 addr", dstk_addr_o, DST - 8);
        chk("R2 data", dstk_data_o, 64'h1005);
        chk("R3 ssp", ssp_o, SST - 8);
        do_ret(64'h1005);
        chk("R4 pc", pc_o, 64'h1005);
        chk("R4 dsp", dsp_o, DST);
        chk("R4 ssp", ssp_o, SST);
        chk("R4 vld", {63'b0, pc_vld_o}, 64'h1);
    endtask

    task automatic test_mismatch();
        do_call(64'h1100, 4'd3, 64'h2200);
        do_ret(64'hDEAD);
        chk("R5 flt", {60'b0, flt_o}, 64'h1);
        chk("R5 pc", pc_o, 64'h2200);
        chk("R5 dsp", dsp_o, DST - 8);
        chk("R5 ssp", ssp_o, SST - 8);
        chk("R5 vld", {63'b0, pc_vld_o}, 64'h0);
        do_call(64'h0, 4'd1, 64'h9999);
        chk("R10 ignored call dsp", dsp_o, DST - 8);
        chk("R10 sticky", {60'b0, flt_o}, 64'h1);
        do_clr();
        chk("R10 cleared", {60'b0, flt_o}, 64'h0);
        do_ret(64'h1103);
        chk("R4 pop pc", pc_o, 64'h1103);
        chk("R4 pop ssp", ssp_o, SST);
    endtask

    task automatic test_gp();
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            st_vld = 1; pg_present = k[2]; pg_writable = k[1]; pg_dirty = k[0];
            @(negedge clk);
            idle();
            chk("R6 flt", {60'b0, flt_o}, (k == 5) ? 64'h2 : 64'h0);
            if (k == 5) do_clr();
        end
        @(negedge clk);
        st_vld = 1; pg_present = 1; pg_writable = 0; pg_dirty = 1;
        call_vld = 1; call_pc = 64'h40; call_len = 4'd2; call_tgt = 64'h80;
        @(negedge clk);
        idle();
        chk("R6 call dropped", dsp_o, DST);
        chk("R6 flt", {60'b0, flt_o}, 64'h2);
        do_clr();
    endtask

    task automatic test_depth();
        for (int i = 0; i < 16; i++) do_call(64'h100 * (i + 1), 4'd2, 64'h5000 + i);
        chk("R7 full ssp", ssp_o, SST - 128);
        do_call(64'h7777, 4'd2, 64'h8888);
        chk("R7 ovf", {60'b0, flt_o}, 64'h4);
        chk("R7 ssp", ssp_o, SST - 128);
        chk("R7 dsp", dsp_o, DST - 128);
        do_clr();
        for (int i = 15; i >= 0; i--) do_ret(64'h100 * (i + 1) + 2);
        chk("R4 lifo pc", pc_o, 64'h102);
        chk("R4 lifo flt", {60'b0, flt_o}, 64'h0);
        chk("R4 lifo ssp", ssp_o, SST);
        do_ret(64'h1234);
        chk("R8 unf", {60'b0, flt_o}, 64'h8);
        chk("R8 dsp", dsp_o, DST);
        do_clr();
    endtask

    task automatic test_disable();
        en = 0;
        do_ret(64'h5555);
        chk("R9 pc", pc_o, 64'h5555);
        chk("R9 dsp", dsp_o, DST + 8);
        chk("R9 ssp", ssp_o, SST);
        chk("R9 flt", {60'b0, flt_o}, 64'h0);
        do_call(64'h10, 4'd4, 64'h20);
        chk("R9 call ssp", ssp_o, SST);
        chk("R9 call dsp", dsp_o, DST);
        en = 1;
    endtask

    task automatic test_ssp_port();
        logic [63:0] saved;
        do_call(64'h3000, 4'd3, 64'h3100);
        saved = ssp_o;
        chk("R11 read", saved, SST - 8);
        edsp = dsp_o;
        @(negedge clk);
        ssp_wr = 1; ssp_wdata = SST;
        call_vld = 1; call_pc = 64'h1; call_len = 4'd1; call_tgt = 64'h2;
        @(negedge clk);
        idle();
        chk("R11 load", ssp_o, SST);
        chk("R11 call dropped", dsp_o, edsp);
        do_ret(64'h3003);
        chk("R11 swapped out", {60'b0, flt_o}, 64'h8);
        do_clr();
        @(negedge clk);
        ssp_wr = 1; ssp_wdata = saved;
        @(negedge clk);
        idle();
        do_ret(64'h3003);
        chk("R11 restored pc", pc_o, 64'h3003);
        chk("R11 restored flt", {60'b0, flt_o}, 64'h0);
        chk("R11 restored ssp", ssp_o, SST);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        test_reset();
        test_call_ret();
        test_mismatch();
        test_gp();
        test_depth();
        test_disable();
        test_ssp_port();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule